// File: doc/BRIEF.md
# Triangular Spread-Spectrum Frequency Modulator

This block sweeps a numerically controlled oscillator back and forth around a nominal frequency, so the energy of the generated clock is spread over a band instead of concentrating in one spectral line. A triangular profile drives the sweep. It starts at the lowest word, rises linearly to the highest, then falls back to the lowest. Each cycle of the system clock, the modulated frequency control word is added into a phase accumulator, and the top phase bit is the output clock.

Two spreading shapes are available. Symmetric spreading puts equal deviation above and below the nominal word, so the mean frequency is unchanged. One-sided spreading keeps the highest point exactly on the nominal word and places all deviation below it, which suits loads with a hard frequency ceiling. A 4-bit depth code sets the span. A rate select chooses a long sweep (for slow downstream loops) or a short one. New settings are applied only when a new sweep begins, and each sweep start is marked by a one-cycle pulse at the low point.

An active-low power-down input stops everything. The sweep is parked, the accumulator is cleared and the output clock is held low. When power-down is released, the sweep starts again from its low point.

Top module: `ssc_modulator`

## Requirements
- R1: One sweep lasts 2·H system cycles, with H = 2^L. The phase p counts 0 to 2H-1, and the position is t = p for p ≤ H, otherwise 2H-p. While spreading, fcwMod = base + ((span·t) >> L), truncated to FCW_W bits.
- R2: span = (fcwNom·(k+1)·STEP_Q) >> FRAC_W, where k is the 4-bit ampCode (0..15). With the defaults STEP_Q=164 and FRAC_W=16, the full span is about (k+1)·0.25 % of nominal.
- R3: With downMode=0 (symmetric), base = fcwNom - (span>>1). The mean of fcwMod over one sweep lies within 1 of fcwNom.
- R4: With downMode=1 (one-sided), base = fcwNom - span. The peak at p = H equals fcwNom exactly.
- R5: rateSel=0 selects L = SLOW_HALF_LOG2 (long sweep). rateSel=1 selects L = FAST_HALF_LOG2 (short sweep).
- R6: periodStrobe is high for exactly one cycle, the cycle with p = 0, and only while spreading is active (pwrDnN=1 and spreadEn=1).
- R7: downMode, ampCode, rateSel and the fcwNom used for span are sampled only on the last cycle of a sweep or in any cycle where spreading is inactive. A change in the middle of a sweep leaves the rest of that sweep unchanged.
- R8: While spreadEn=0, fcwMod equals fcwNom exactly and no strobe is produced. On the first enabled cycle the sweep starts at p = H/2 (mid-span, rising), and the next strobe comes 3H/2 cycles later.
- R9: While pwrDnN=0, ncoClk is low in the same cycle, fcwMod equals fcwNom, no strobe is produced and the accumulator is held at zero.
- R10: The first cycle after pwrDnN returns high with spreadEn=1 has p = 0 (strobe high, lowest word), and the accumulator starts from zero.
- R11: On each clock edge with pwrDnN=1, the accumulator adds fcwMod modulo 2^FCW_W. ncoClk is the accumulator's top bit.
- R12: rst_n is asynchronous and active low. It leaves p = 0, an accumulator of zero, and settings of long sweep, symmetric and span zero until the first load allowed by R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwrDnN | input | 1 | Power-down, active low |
| spreadEn | input | 1 | Enables the sweep |
| downMode | input | 1 | 0 symmetric spreading, 1 one-sided (below nominal) |
| ampCode | input | AMP_W (4) | Depth code k |
| rateSel | input | 1 | 0 long sweep, 1 short sweep |
| fcwNom | input | FCW_W (32) | Nominal frequency control word |
| fcwMod | output | FCW_W (32) | Instantaneous modulated control word |
| periodStrobe | output | 1 | One-cycle pulse at the start of each sweep |
| ncoClk | output | 1 | Top bit of the phase accumulator |

## Verification
fcwMod and periodStrobe are decoded from the registered phase, so they are valid in the same cycle the phase reaches a value. After the first enabled cycle or a power-down release, the bench samples them once per cycle, one time unit after the falling edge. A setting changed in the middle of a sweep is expected to show only from the first cycle of the following sweep, and the bench checks the remaining cycles of the old sweep against the old settings. ncoClk in cycle n reflects the sum of the words from cycles 0 to n-1, while power-down forces it low in the same cycle, and the bench keeps its own accumulator to match that one-cycle lag.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // strobes from the sweep control to the word datapath
  typedef struct packed {
    logic active;   // sweep is running this cycle
    logic loadCfg;  // capture settings and span at the coming edge
  } ssc_ctl_t;
endpackage

// File: rtl/ssc_sweep_ctl.sv
module ssc_sweep_ctl
  import ssc_pkg::*;
#(
  parameter int SLOW_L = 5,
  parameter int FAST_L = 3,
  localparam int PH_W = SLOW_L + 2,
  localparam int SH_W = $clog2(SLOW_L + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwrDnN,
  input  logic            spreadEn,
  input  logic            rateSel,
  output ssc_ctl_t        ctl,
  output logic            periodStart,
  output logic [PH_W-1:0] triPos,
  output logic [SH_W-1:0] shiftL
);
  localparam logic [PH_W-1:0] HALF_SLOW = PH_W'(1) << SLOW_L;
  localparam logic [PH_W-1:0] HALF_FAST = PH_W'(1) << FAST_L;

  logic            rateQ;
  logic [PH_W-1:0] phQ, phNext, halfCur, halfIn, fullCur;
  logic            active, lastCyc;

  always_comb begin
    halfCur = rateQ ? HALF_FAST : HALF_SLOW;
    halfIn  = rateSel ? HALF_FAST : HALF_SLOW;
    fullCur = halfCur << 1;
    active  = pwrDnN & spreadEn;
    lastCyc = active && (phQ == fullCur - PH_W'(1));
  end

  // next phase: power-down parks at the low point, disable parks mid-span
  always_comb begin
    if (!pwrDnN)        phNext = '0;
    else if (!spreadEn) phNext = halfIn >> 1;
    else if (lastCyc)   phNext = '0;
    else                phNext = phQ + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phQ   <= '0;
      rateQ <= 1'b0;
    end else begin
      phQ <= phNext;
      if (ctl.loadCfg) rateQ <= rateSel;
    end
  end

  always_comb begin
    ctl.active  = active;
    ctl.loadCfg = !active || lastCyc;
    periodStart = active && (phQ == '0);
    triPos      = (phQ <= halfCur) ? phQ : (fullCur - phQ);
    shiftL      = rateQ ? SH_W'(FAST_L) : SH_W'(SLOW_L);
  end
endmodule

// File: rtl/ssc_fcw_path.sv
module ssc_fcw_path
  import ssc_pkg::*;
#(
  parameter int FCW_W  = 32,
  parameter int AMP_W  = 4,
  parameter int STEP_Q = 164,
  parameter int FRAC_W = 16,
  parameter int PH_W   = 7,
  parameter int SH_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrDnN,
  input  ssc_ctl_t         ctl,
  input  logic             downMode,
  input  logic [AMP_W-1:0] ampCode,
  input  logic [FCW_W-1:0] fcwNom,
  input  logic [PH_W-1:0]  triPos,
  input  logic [SH_W-1:0]  shiftL,
  output logic [FCW_W-1:0] fcwMod,
  output logic             ncoClk
);
  localparam int STEP_W = $clog2(STEP_Q + 1);
  localparam int PROD_W = FCW_W + AMP_W + 1 + STEP_W;
  localparam int OFF_W  = FCW_W + PH_W;

  logic [PROD_W-1:0] spanProd;
  logic [FCW_W-1:0]  spanNext, spanQ, base, offset;
  logic [OFF_W-1:0]  offProd;
  logic              downQ;
  logic [FCW_W-1:0]  accQ;

  // span of the coming sweep: nominal times depth fraction
  always_comb begin
    spanProd = PROD_W'(fcwNom)
             * PROD_W'({1'b0, ampCode} + (AMP_W + 1)'(1))
             * PROD_W'(STEP_Q);
    spanNext = FCW_W'(spanProd >> FRAC_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spanQ <= '0;
      downQ <= 1'b0;
    end else if (ctl.loadCfg) begin
      spanQ <= spanNext;
      downQ <= downMode;
    end
  end

  always_comb begin
    offProd = OFF_W'(spanQ) * OFF_W'(triPos);
    offset  = FCW_W'(offProd >> shiftL);
    base    = downQ ? (fcwNom - spanQ) : (fcwNom - (spanQ >> 1));
    fcwMod  = ctl.active ? (base + offset) : fcwNom;
  end

  // phase accumulator; cleared and frozen in power-down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       accQ <= '0;
    else if (!pwrDnN) accQ <= '0;
    else              accQ <= accQ + fcwMod;
  end

  assign ncoClk = accQ[FCW_W-1] & pwrDnN;
endmodule

// File: rtl/ssc_modulator.sv
module ssc_modulator
  import ssc_pkg::*;
#(
  parameter int FCW_W          = 32,
  parameter int AMP_W          = 4,
  parameter int SLOW_HALF_LOG2 = 5,
  parameter int FAST_HALF_LOG2 = 3,
  parameter int STEP_Q         = 164,
  parameter int FRAC_W         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrDnN,
  input  logic             spreadEn,
  input  logic             downMode,
  input  logic [AMP_W-1:0] ampCode,
  input  logic             rateSel,
  input  logic [FCW_W-1:0] fcwNom,
  output logic [FCW_W-1:0] fcwMod,
  output logic             periodStrobe,
  output logic             ncoClk
);
  localparam int PH_W = SLOW_HALF_LOG2 + 2;
  localparam int SH_W = $clog2(SLOW_HALF_LOG2 + 1);

  ssc_ctl_t        ctl;
  logic [PH_W-1:0] triPos;
  logic [SH_W-1:0] shiftL;

  ssc_sweep_ctl #(
    .SLOW_L(SLOW_HALF_LOG2),
    .FAST_L(FAST_HALF_LOG2)
  ) uCtl (
    .clk(clk), .rst_n(rst_n), .pwrDnN(pwrDnN), .spreadEn(spreadEn),
    .rateSel(rateSel), .ctl(ctl), .periodStart(periodStrobe),
    .triPos(triPos), .shiftL(shiftL)
  );

  ssc_fcw_path #(
    .FCW_W(FCW_W), .AMP_W(AMP_W), .STEP_Q(STEP_Q), .FRAC_W(FRAC_W),
    .PH_W(PH_W), .SH_W(SH_W)
  ) uPath (
    .clk(clk), .rst_n(rst_n), .pwrDnN(pwrDnN), .ctl(ctl),
    .downMode(downMode), .ampCode(ampCode), .fcwNom(fcwNom),
    .triPos(triPos), .shiftL(shiftL), .fcwMod(fcwMod), .ncoClk(ncoClk)
  );
endmodule

// File: rtl/ssc_modulator_chk.sv
module ssc_modulator_chk #(
  parameter int FCW_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwrDnN,
  input logic             spreadEn,
  input logic [FCW_W-1:0] fcwNom,
  input logic [FCW_W-1:0] fcwMod,
  input logic             periodStrobe,
  input logic             ncoClk
);
  // R9: power-down silences the clock and the strobe at once
  assert_pd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrDnN |-> (!ncoClk && !periodStrobe));

  // R8: disabled spreading passes the nominal word through untouched
  assert_disabled_nominal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrDnN && !spreadEn) |-> (fcwMod == fcwNom && !periodStrobe));

  // R6: the sweep-start pulse never lasts two cycles
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    periodStrobe |=> !periodStrobe);

  // R10: leaving power-down with spreading on starts a fresh sweep
  assert_restart_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwrDnN) && spreadEn) |-> periodStrobe);

  // R8: re-enabling resumes mid-span, so no pulse on that cycle
  assert_enable_midspan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spreadEn) && pwrDnN && $past(pwrDnN)) |-> !periodStrobe);
endmodule

bind ssc_modulator ssc_modulator_chk #(.FCW_W(FCW_W)) uChk (
  .clk(clk), .rst_n(rst_n), .pwrDnN(pwrDnN), .spreadEn(spreadEn),
  .fcwNom(fcwNom), .fcwMod(fcwMod), .periodStrobe(periodStrobe),
  .ncoClk(ncoClk)
);

// File: tb/ssc_modulator_test.sv
module ssc_modulator_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  SLOW_L = 5;
  localparam int  FAST_L = 3;
  localparam longint NOM  = 64'h1000_0000;
  localparam longint MASK = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n, pwrDnN, spreadEn, downMode, rateSel;
  logic [3:0]  ampCode;
  logic [31:0] fcwNom;
  logic [31:0] fcwMod;
  logic        periodStrobe, ncoClk;

  int     nChecks = 0;
  int     nFail = 0;
  longint accM = 0;
  longint sumAct = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssc_modulator #(.SLOW_HALF_LOG2(SLOW_L), .FAST_HALF_LOG2(FAST_L)) uut (
    .clk(clk), .rst_n(rst_n), .pwrDnN(pwrDnN), .spreadEn(spreadEn),
    .downMode(downMode), .ampCode(ampCode), .rateSel(rateSel),
    .fcwNom(fcwNom), .fcwMod(fcwMod), .periodStrobe(periodStrobe),
    .ncoClk(ncoClk)
  );

  // expected word from R1..R4; amp = -1 models the zero span left by reset
  function automatic longint expWord(bit down, int amp, int L, int ph);
    longint span = (NOM * longint'(amp + 1) * 164) >> 16;
    longint h    = longint'(1) << L;
    longint t    = (ph <= h) ? longint'(ph) : 2 * h - ph;
    longint base = down ? NOM - span : NOM - (span >> 1);
    return (base + ((span * t) >> L)) & MASK;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called just after a falling edge; checks n cycles from phase startPh
  task automatic runSweep(string req, bit down, int amp, int L, int startPh,
                          int n, bit trackNco);
    for (int i = 0; i < n; i++) begin
      int     ph = (startPh + i) % (2 << L);
      longint e  = expWord(down, amp, L, ph);
      #1;
      check(req, "fcwMod", longint'(fcwMod), e);
      check(req, "periodStrobe", longint'(periodStrobe), longint'(ph == 0));
      if (trackNco) check(req, "ncoClk", longint'(ncoClk), (accM >> 31) & 1);
      accM   = (accM + e) & MASK;
      sumAct = sumAct + longint'(fcwMod);
      @(negedge clk);
    end
  endtask

  // hold power-down for two cycles with new settings, then release
  task automatic pdCycle(bit down, int amp, bit rate);
    pwrDnN = 1'b0; spreadEn = 1'b1;
    downMode = down; ampCode = 4'(amp); rateSel = rate;
    #1;
    check("R9", "ncoClk in power-down", longint'(ncoClk), 0);
    check("R9", "fcwMod in power-down", longint'(fcwMod), NOM);
    check("R9", "strobe in power-down", longint'(periodStrobe), 0);
    @(negedge clk);
    @(negedge clk);
    pwrDnN = 1'b1;
    accM = 0;
  endtask

  task automatic testReset();
    rst_n = 1'b0; pwrDnN = 1'b1; spreadEn = 1'b1;
    downMode = 1'b0; ampCode = 4'd15; rateSel = 1'b1; fcwNom = NOM[31:0];
    repeat (3) @(negedge clk);
    #1 check("R12", "ncoClk under reset", longint'(ncoClk), 0);
    @(negedge clk);
    rst_n = 1'b1;
    accM = 0;
    // defaults: long sweep, zero span, strobe at phase 0, NCO from zero (R11)
    runSweep("R12", 1'b0, -1, SLOW_L, 0, 2 << SLOW_L, 1'b1);
  endtask

  task automatic testDown();
    pdCycle(1'b1, 3, 1'b0);
    // R10 restart, R1 triangle, R4 one-sided peak, R11 accumulator
    runSweep("R10_R4_R1", 1'b1, 3, SLOW_L, 0, 2 << SLOW_L, 1'b1);
    check("R4", "peak equals nominal", expWord(1'b1, 3, SLOW_L, 1 << SLOW_L), NOM);
  endtask

  task automatic testCenterFast();
    pdCycle(1'b0, 15, 1'b1);
    sumAct = 0;
    runSweep("R3_R5", 1'b0, 15, FAST_L, 0, 2 << FAST_L, 1'b1);
    begin
      longint avg = sumAct / (2 << FAST_L);
      longint dif = (avg > NOM) ? avg - NOM : NOM - avg;
      check("R3", "mean within 1 of nominal", longint'(dif <= 1), 1);
    end
  endtask

  task automatic testCenterMin();
    pdCycle(1'b0, 0, 1'b0);
    runSweep("R2", 1'b0, 0, SLOW_L, 0, 2 << SLOW_L, 1'b1);
  endtask

  task automatic testMidChange();
    pdCycle(1'b1, 3, 1'b0);
    runSweep("R7", 1'b1, 3, SLOW_L, 0, 11, 1'b1);
    downMode = 1'b0; ampCode = 4'd15; rateSel = 1'b1;
    runSweep("R7", 1'b1, 3, SLOW_L, 11, (2 << SLOW_L) - 11, 1'b1);
    runSweep("R7_R5", 1'b0, 15, FAST_L, 0, 2 << FAST_L, 1'b1);
  endtask

  task automatic testDisable();
    spreadEn = 1'b0; rateSel = 1'b0; downMode = 1'b1; ampCode = 4'd7;
    for (int i = 0; i < 20; i++) begin
      #1;
      check("R8", "fcwMod while disabled", longint'(fcwMod), NOM);
      check("R8", "strobe while disabled", longint'(periodStrobe), 0);
      @(negedge clk);
    end
    spreadEn = 1'b1;
    runSweep("R8_R6", 1'b1, 7, SLOW_L, 1 << (SLOW_L - 1),
             (2 << SLOW_L) - (1 << (SLOW_L - 1)) + 1, 1'b0);
  endtask

  initial begin
    testReset();
    testDown();
    testCenterFast();
    testCenterMin();
    testMidChange();
    testDisable();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule